// File: doc/BRIEF.md
# Parallel LCD Write Cycle Sequencer

This block runs a single write transfer on an 8080-style parallel display bus. A client offers an address (or command) word and a data word through a valid/ready handshake. Once the request is taken, the block walks the bus through four timed phases: address valid before chip select, chip select before the write strobe, the write strobe pulse itself, and the hold from strobe release to chip-select release. Each phase lasts its programmed count plus one clock. Chip select and the write strobe are active low and sit high while the bus is idle.

The four phase counts live in internal timing registers. These registers take the values on the configuration inputs whenever `cfg_load` is high, and after reset they hold 0, 0, 1 and 0 (address setup, strobe setup, strobe width, hold). The registers are copied into a private snapshot when a request is accepted, so reprogramming them in the middle of a transfer only affects later transfers. A one-clock `done` pulse marks the end of each transfer.

The controller is a five-state machine. ST_IDLE waits for a request. ST_ADDR is the address-setup phase. ST_CSWR is the chip-select-to-strobe phase. ST_WRLO holds the strobe low. ST_HOLD is the strobe-release-to-deselect phase. The transitions are: IDLE to ADDR on an accepted request. ADDR to CSWR, CSWR to WRLO and WRLO to HOLD, each when the phase counter reaches zero. HOLD to IDLE when its counter reaches zero. A single down-counter is loaded at every transition with the length of the phase being entered.

Top module: `lcd_wr_seq`

## Requirements
- R1: After reset, `lcd_cs_n` and `lcd_wr_n` are high, `req_ready` is high, `done` is low and `lcd_data` is zero.
- R2: After reset, and with no `cfg_load`, a transfer uses address setup 0, strobe setup 0, strobe width 1 and hold 0.
- R3: Counting clock edges from the one that accepts the request (the edge at which the address becomes valid), `lcd_cs_n` goes low cs_setup+1 edges later.
- R4: `lcd_wr_n` goes low wr_setup+1 clock edges after `lcd_cs_n` goes low.
- R5: `lcd_wr_n` stays low for exactly wr_active+1 clocks.
- R6: `lcd_cs_n` returns high wr_hold+1 clock edges after `lcd_wr_n` returns high.
- R7: `lcd_data` carries the request's data word from the edge where `lcd_wr_n` falls until the edge where `lcd_cs_n` rises, and is zero at every other time.
- R8: `lcd_addr` shows the request's address from the accepting edge until `lcd_cs_n` rises, and does not change during that time.
- R9: A request is taken only while `req_ready` is high. `req_ready` is low from the accepting edge until `lcd_cs_n` rises. Changes to `req_valid`, `req_addr` or `req_data` during a transfer have no effect on it.
- R10: `done` is high for exactly one clock, starting at the same edge at which `lcd_cs_n` rises.
- R11: A `cfg_load` issued during a transfer leaves that transfer's timing unchanged and applies to the next transfer.
- R12: `lcd_wr_n` is never low while `lcd_cs_n` is high.
- R13: Each timing field is 4 bits wide, so every phase lasts between 1 and 16 clocks. The field values 0 and 15 produce the two extreme lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Idle; a request is taken at this edge if offered |
| req_addr | input | ADDR_W | Address or command word of the request |
| req_data | input | DATA_W | Data word of the request |
| cfg_load | input | 1 | Load the four timing fields into the timing registers |
| cfg_cs_setup | input | 4 | Address-to-select phase count |
| cfg_wr_setup | input | 4 | Select-to-strobe phase count |
| cfg_wr_active | input | 4 | Strobe width count |
| cfg_wr_hold | input | 4 | Strobe-release-to-deselect count |
| done | output | 1 | One-clock end-of-transfer pulse |
| lcd_addr | output | ADDR_W | Address bus |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_data | output | DATA_W | Data bus |

## Verification
Every bus output is decoded from the registered state, so it changes at a clock edge. The accepting edge is called edge 0. Relative to it, select falls at edge cs_setup+1. The strobe falls wr_setup+1 edges after that, rises wr_active+1 edges later, and select rises (with the `done` pulse and `req_ready`) wr_hold+1 edges after the strobe rises. The bench samples all outputs at the falling clock edge after each rising edge, numbers those samples from the accepting edge, and records the first sample at which each edge is seen. It then compares those sample numbers with sums of the programmed counts that it computes itself. The address, data, ready and done outputs are checked at every sample against the window those sums define.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

    // Width of each timing field; a field value N gives N+1 clocks.
    localparam int TW = 4;

    typedef logic [TW-1:0] tfield_t;

    typedef struct packed {
        tfield_t cs_setup;
        tfield_t wr_setup;
        tfield_t wr_active;
        tfield_t wr_hold;
    } timing_t;

    localparam timing_t TIMING_RST = '{
        cs_setup:  tfield_t'(0),
        wr_setup:  tfield_t'(0),
        wr_active: tfield_t'(1),
        wr_hold:   tfield_t'(0)
    };

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CSWR,
        ST_WRLO,
        ST_HOLD
    } state_t;

endpackage

// File: rtl/lcd_wr_timing_regs.sv
module lcd_wr_timing_regs
    import lcd_wr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  timing_t load_val,
    input  logic    capture,
    output timing_t live,
    output timing_t snap
);

    // Programmed timing, reset to the defaults.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live <= TIMING_RST;
        end else if (load) begin
            live <= load_val;
        end
    end

    // Copy used by the transfer in progress.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap <= TIMING_RST;
        end else if (capture) begin
            snap <= live;
        end
    end

endmodule

// File: rtl/lcd_wr_phase_cnt.sv
module lcd_wr_phase_cnt
    import lcd_wr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  tfield_t load_val,
    input  logic    dec,
    output logic    zero
);

    tfield_t cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - tfield_t'(1);
        end
    end

    assign zero = (cnt_q == '0);

    // R13: a phase never counts below its zero end
    // R13
    cnt_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !zero);

    // R13
    cnt_ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec));

endmodule

// File: rtl/lcd_wr_fsm.sv
module lcd_wr_fsm
    import lcd_wr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  timing_t           tim_live,
    input  timing_t           tim_snap,
    input  logic              cnt_zero,
    output logic              accept,
    output logic              cnt_load,
    output tfield_t           cnt_load_val,
    output logic              cnt_dec,
    output logic              req_ready,
    output logic              done,
    output logic [ADDR_W-1:0] lcd_addr,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic [DATA_W-1:0] lcd_data
);

    state_t            state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and phase counter control
    always_comb begin
        state_d      = state_q;
        accept       = 1'b0;
        cnt_load     = 1'b0;
        cnt_dec      = 1'b0;
        cnt_load_val = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept       = 1'b1;
                    state_d      = ST_ADDR;
                    cnt_load     = 1'b1;
                    cnt_load_val = tim_live.cs_setup;
                end
            end
            ST_ADDR: begin
                if (cnt_zero) begin
                    state_d      = ST_CSWR;
                    cnt_load     = 1'b1;
                    cnt_load_val = tim_snap.wr_setup;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_CSWR: begin
                if (cnt_zero) begin
                    state_d      = ST_WRLO;
                    cnt_load     = 1'b1;
                    cnt_load_val = tim_snap.wr_active;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_WRLO: begin
                if (cnt_zero) begin
                    state_d      = ST_HOLD;
                    cnt_load     = 1'b1;
                    cnt_load_val = tim_snap.wr_hold;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture and end-of-transfer pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= req_addr;
                data_q <= req_data;
            end
            done_q <= (state_q == ST_HOLD) && cnt_zero;
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        lcd_cs_n  = 1'b1;
        lcd_wr_n  = 1'b1;
        lcd_data  = '0;
        lcd_addr  = addr_q;
        done      = done_q;
        unique case (state_q)
            ST_CSWR: lcd_cs_n = 1'b0;
            ST_WRLO: begin
                lcd_cs_n = 1'b0;
                lcd_wr_n = 1'b0;
                lcd_data = data_q;
            end
            ST_HOLD: begin
                lcd_cs_n = 1'b0;
                lcd_data = data_q;
            end
            default: ;
        endcase
    end

    // R12
    wr_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_wr_n) |-> !lcd_cs_n);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_with_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($rose(lcd_cs_n) && req_ready));

    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (req_ready || $stable(lcd_addr)));

    // R11
    snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(tim_snap));

    // R7
    data_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cs_n |-> (lcd_data == '0));

endmodule

// File: rtl/lcd_wr_seq.sv
module lcd_wr_seq
    import lcd_wr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              cfg_load,
    input  logic [TW-1:0]     cfg_cs_setup,
    input  logic [TW-1:0]     cfg_wr_setup,
    input  logic [TW-1:0]     cfg_wr_active,
    input  logic [TW-1:0]     cfg_wr_hold,
    output logic              done,
    output logic [ADDR_W-1:0] lcd_addr,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic [DATA_W-1:0] lcd_data
);

    timing_t cfg_in;
    timing_t tim_live;
    timing_t tim_snap;
    logic    accept;
    logic    cnt_load;
    logic    cnt_dec;
    logic    cnt_zero;
    tfield_t cnt_load_val;

    assign cfg_in = '{
        cs_setup:  cfg_cs_setup,
        wr_setup:  cfg_wr_setup,
        wr_active: cfg_wr_active,
        wr_hold:   cfg_wr_hold
    };

    lcd_wr_timing_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .load_val (cfg_in),
        .capture  (accept),
        .live     (tim_live),
        .snap     (tim_snap)
    );

    lcd_wr_phase_cnt u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    lcd_wr_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .tim_live     (tim_live),
        .tim_snap     (tim_snap),
        .cnt_zero     (cnt_zero),
        .accept       (accept),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .cnt_dec      (cnt_dec),
        .req_ready    (req_ready),
        .done         (done),
        .lcd_addr     (lcd_addr),
        .lcd_cs_n     (lcd_cs_n),
        .lcd_wr_n     (lcd_wr_n),
        .lcd_data     (lcd_data)
    );

    // R9
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !lcd_cs_n) |=> (!req_ready || lcd_cs_n));

endmodule

// File: tb/tb_lcd_wr_seq.sv
module tb_lcd_wr_seq;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NV = 5;

    // {cs_setup, wr_setup, wr_active, wr_hold, addr, data}
    localparam logic [39:0] VEC [NV] = '{
        {4'd1,  4'd2,  4'd0,  4'd3,  8'hA5, 16'h1234},
        {4'd0,  4'd0,  4'd0,  4'd0,  8'h3C, 16'hBEEF},
        {4'd15, 4'd15, 4'd15, 4'd15, 8'hFF, 16'hFFFF},
        {4'd5,  4'd0,  4'd7,  4'd1,  8'h01, 16'h8001},
        {4'd0,  4'd9,  4'd2,  4'd15, 8'h80, 16'h0F0F}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          cfg_load = 1'b0;
    logic [3:0]    cfg_cs_setup = '0;
    logic [3:0]    cfg_wr_setup = '0;
    logic [3:0]    cfg_wr_active = '0;
    logic [3:0]    cfg_wr_hold = '0;
    logic          done;
    logic [AW-1:0] lcd_addr;
    logic          lcd_cs_n;
    logic          lcd_wr_n;
    logic [DW-1:0] lcd_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lcd_wr_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_data      (req_data),
        .cfg_load      (cfg_load),
        .cfg_cs_setup  (cfg_cs_setup),
        .cfg_wr_setup  (cfg_wr_setup),
        .cfg_wr_active (cfg_wr_active),
        .cfg_wr_hold   (cfg_wr_hold),
        .done          (done),
        .lcd_addr      (lcd_addr),
        .lcd_cs_n      (lcd_cs_n),
        .lcd_wr_n      (lcd_wr_n),
        .lcd_data      (lcd_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load_cfg(input int cs, input int ws, input int wa, input int wh);
        @(negedge clk);
        cfg_cs_setup  = 4'(cs);
        cfg_wr_setup  = 4'(ws);
        cfg_wr_active = 4'(wa);
        cfg_wr_hold   = 4'(wh);
        cfg_load      = 1'b1;
        @(negedge clk);
        cfg_load      = 1'b0;
    endtask

    // Samples are taken at falling edges; sample t follows rising edge t,
    // where edge 0 accepts the request.
    task automatic xfer(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int ecs, input int ews, input int ewa, input int ewh,
                        input bit poke, input bit mid_cfg);
        int t_csf, t_wrf, t_wrr, t_csr, done_n, done_t;
        int bad_addr, bad_data, bad_ready, bad_wr;
        int e_csf, e_wrf, e_wrr, e_csr;
        logic [DW-1:0] exp_d;
        t_csf = -1; t_wrf = -1; t_wrr = -1; t_csr = -1;
        done_n = 0; done_t = -1;
        bad_addr = 0; bad_data = 0; bad_ready = 0; bad_wr = 0;
        e_csf = ecs + 1;
        e_wrf = e_csf + ews + 1;
        e_wrr = e_wrf + ewa + 1;
        e_csr = e_wrr + ewh + 1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R9 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        for (int t = 0; t < 80; t++) begin
            @(negedge clk);
            if (t == 0) begin
                if (poke) begin
                    req_addr = ~a;
                    req_data = ~d;
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (mid_cfg && t == 1) begin
                cfg_cs_setup = 4'd3; cfg_wr_setup = 4'd3;
                cfg_wr_active = 4'd3; cfg_wr_hold = 4'd3;
                cfg_load = 1'b1;
            end
            if (mid_cfg && t == 2) cfg_load = 1'b0;
            if (t_csf < 0 && lcd_cs_n === 1'b0) t_csf = t;
            if (t_csf >= 0 && t_wrf < 0 && lcd_wr_n === 1'b0) t_wrf = t;
            if (t_wrf >= 0 && t_wrr < 0 && lcd_wr_n === 1'b1) t_wrr = t;
            if (t_csf >= 0 && t_csr < 0 && lcd_cs_n === 1'b1) t_csr = t;
            if (done === 1'b1) begin
                done_n++;
                done_t = t;
            end
            if (lcd_wr_n === 1'b0 && lcd_cs_n !== 1'b0) bad_wr++;
            exp_d = (t_wrf >= 0 && t_csr < 0) ? d : '0;
            if (lcd_data !== exp_d) bad_data++;
            if (t_csr < 0) begin
                if (lcd_addr !== a) bad_addr++;
                if (req_ready !== 1'b0) bad_ready++;
            end else begin
                if (req_ready !== 1'b1) bad_ready++;
                req_valid = 1'b0;
                break;
            end
        end
        chk(t_csf == e_csf, "R3 select fall edge", t_csf, e_csf);
        chk(t_wrf == e_wrf, "R4 strobe fall edge", t_wrf, e_wrf);
        chk(t_wrr - t_wrf == ewa + 1, "R5 strobe width", t_wrr - t_wrf, ewa + 1);
        chk(t_csr - t_wrr == ewh + 1, "R6 select hold", t_csr - t_wrr, ewh + 1);
        chk(bad_data == 0, "R7 data window", bad_data, 0);
        chk(bad_addr == 0, "R8 address held", bad_addr, 0);
        chk(bad_ready == 0, "R9 ready low while busy", bad_ready, 0);
        chk(done_n == 1 && done_t == t_csr, "R10 done at select rise", done_t, t_csr);
        chk(bad_wr == 0, "R12 strobe inside select", bad_wr, 0);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one clock", int'(done), 0);
        chk(lcd_cs_n === 1'b1 && req_ready === 1'b1, "R9 no second transfer",
            int'(lcd_cs_n), 1);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle state after reset
        chk(lcd_cs_n === 1'b1, "R1 select idle high", int'(lcd_cs_n), 1);
        chk(lcd_wr_n === 1'b1, "R1 strobe idle high", int'(lcd_wr_n), 1);
        chk(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(done === 1'b0, "R1 done low", int'(done), 0);
        chk(lcd_data === '0, "R1 data zero", int'(lcd_data), 0);

        // R2 reset-default timing 0,0,1,0
        xfer(8'h5A, 16'hC3C3, 0, 0, 1, 0, 1'b0, 1'b0);

        // Table walk, includes R13 extremes 0 and 15
        for (int i = 0; i < NV; i++) begin
            load_cfg(int'(VEC[i][39:36]), int'(VEC[i][35:32]),
                     int'(VEC[i][31:28]), int'(VEC[i][27:24]));
            xfer(VEC[i][23:16], VEC[i][15:0],
                 int'(VEC[i][39:36]), int'(VEC[i][35:32]),
                 int'(VEC[i][31:28]), int'(VEC[i][27:24]), 1'b0, 1'b0);
        end

        // R9 request inputs changed and held valid during a transfer
        load_cfg(2, 1, 3, 2);
        xfer(8'h11, 16'h2222, 2, 1, 3, 2, 1'b1, 1'b0);

        // R11 reprogramming mid-transfer: current keeps 2,1,3,2, next uses 3,3,3,3
        xfer(8'h44, 16'h5555, 2, 1, 3, 2, 1'b0, 1'b1);
        xfer(8'h66, 16'h7777, 3, 3, 3, 3, 1'b0, 1'b0);

        // R1 reset mid-transfer returns the bus to idle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 8'h99; req_data = 16'hAAAA;
        repeat (6) @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(lcd_cs_n === 1'b1 && lcd_wr_n === 1'b1, "R1 reset idles bus",
            int'(lcd_cs_n), 1);
        chk(req_ready === 1'b1 && lcd_data === '0, "R1 reset ready and data",
            int'(req_ready), 1);
        rst_n = 1'b1;
        // R2 defaults restored by reset
        xfer(8'h0F, 16'hF00F, 0, 0, 1, 0, 1'b0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule